// File: doc/BRIEF.md
# Half-Bridge Driver Serial Control and Status Port

This block is the slave side of a four-wire serial port for a six-half-bridge driver controller. While its select input is low, an external controller clocks a 16-bit control word into the data input. At the same time the block shifts a 16-bit status word out on a data output that is driven only while the port is selected. Both words travel least-significant bit first. The status word comes from the protection logic and is captured when select falls. Its bit 0, the temperature prewarning, is visible on the output straight away, so a master can read it by pulsing select alone.

The received word is committed to the control register only when select rises after exactly 16 serial clock falling edges. The commit is marked by a one-cycle strobe towards the protection logic. A second one-cycle strobe accompanies it when bit 0 of the new word, the status reset request, is set. A frame with any other count leaves the control register as it was. After the 16 status bits, the output repeats the bits received on the input 16 clocks earlier, so that several ports can be chained. The serial clock, select and data inputs are oversampled by a system clock that runs at least 8 times faster than the serial clock.

Frame control is a four-state machine:
- ST_IDLE: select is high and the output is off. A select fall moves it to ST_SHIFT.
- ST_SHIFT: it counts serial clock falls. The 16th fall moves it to ST_FULL, and a select rise returns it to ST_IDLE without a commit.
- ST_FULL: a select rise commits the word and returns to ST_IDLE. A further fall moves it to ST_OVER.
- ST_OVER: a select rise returns it to ST_IDLE without a commit.

Top module: `hbser_port`

## Requirements
- R1: After reset, `control_o` is 0xE000: bit 15 (software run enable), bit 14 (short-circuit timer select) and bit 13 (open-load detect disable) are high, and bits 12..0 are low. At the same time `ser_dout_en_o`, `commit_o` and `status_clear_o` are low.
- R2: `ser_dout_en_o` is low while select is high. It rises on the third system clock edge after select falls, and it falls on the third edge after select rises.
- R3: `status_i` is captured at the select fall, and its bit 0 is on `ser_dout_o` as soon as the output is enabled. Changes to `status_i` later in the frame have no effect on the bits shifted out.
- R4: `ser_din_i` is sampled at each serial clock falling edge. Bit n of the committed word is the value sampled at fall n, counting from 0.
- R5: `ser_dout_o` changes only on a serial clock rising edge that follows a falling edge of the same frame, and holds its value between such edges. At fall n, for n < 16, it shows status bit n.
- R6: At fall n, for n >= 16, `ser_dout_o` shows the data input value sampled at fall n-16.
- R7: A select rise after exactly 16 falls loads the received word into `control_o` and raises `commit_o` for one cycle. Both become visible on the third system clock edge after select rises.
- R8: A select rise after any other number of falls, zero included, leaves `control_o` unchanged and produces no `commit_o`.
- R9: `status_clear_o` is high for exactly the commit cycle when bit 0 of the committed word is 1. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk_i | input | 1 | Serial clock, idle low |
| ser_sel_n_i | input | 1 | Active-low frame select |
| ser_din_i | input | 1 | Serial data in, LSB first |
| ser_dout_o | output | 1 | Serial data out, LSB first |
| ser_dout_en_o | output | 1 | Output driver enable; the pad is high impedance when low |
| status_i | input | 16 | Status word from the protection logic |
| control_o | output | 16 | Committed control word |
| commit_o | output | 1 | One-cycle strobe when a control word is committed |
| status_clear_o | output | 1 | One-cycle status reset request |

## Verification
Every serial pin passes through two synchronizer flops and one registered stage. The output enable and the commit results therefore appear on the third system clock edge after a select change. The bench samples on the falling clock edge after the second rising edge to see the old value, and after the third to see the new one. Serial clock phases last six system cycles, so `ser_dout_o` has settled by the time it is compared with the expected bit, just before each serial clock fall. A sweep runs frames of 0 to 20 serial clocks over three data patterns, and compares every output bit, the control word and the strobe counts against values computed from the frame's words.

// File: rtl/hbser_pkg.sv
package hbser_pkg;
    // Number of top control bits that come out of reset high.
    localparam int CTRL_TOP_SET = 3;
    // Control word field that requests a status reset.
    localparam int CTRL_CLR_BIT = 0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_FULL,
        ST_OVER
    } frame_state_e;
endpackage

// File: rtl/hbser_sync.sv
module hbser_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hbser_frame_fsm.sv
module hbser_frame_fsm
    import hbser_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_fall_i,
    input  logic sel_rise_i,
    input  logic sck_fall_i,
    output logic active_o,
    output logic take_o,
    output logic commit_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(WORD_W);

    frame_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sel_fall_i) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (sel_rise_i)                              state_d = ST_IDLE;
                else if (sck_fall_i && cnt_q == LAST_FALL)   state_d = ST_FULL;
            end
            ST_FULL: begin
                if (sel_rise_i)      state_d = ST_IDLE;
                else if (sck_fall_i) state_d = ST_OVER;
            end
            ST_OVER:  if (sel_rise_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and fall counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (sel_fall_i)
                cnt_q <= '0;
            else if (state_q == ST_SHIFT && sck_fall_i)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign active_o = (state_q != ST_IDLE);
    assign take_o   = (state_q == ST_FULL) && sel_rise_i;

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) commit_o <= 1'b0;
        else        commit_o <= take_o;
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);
    p_full_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FULL |-> cnt_q == FULL_CNT);
    p_commit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
endmodule

// File: rtl/hbser_shifter.sv
module hbser_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] status_i,
    input  logic              active_i,
    input  logic              sck_fall_i,
    input  logic              sck_rise_i,
    input  logic              din_i,
    output logic [WORD_W-1:0] rx_o,
    output logic              dout_o
);
    logic [WORD_W-1:0] rx_q, tx_q;
    logic              seen_fall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q        <= '0;
            tx_q        <= '0;
            seen_fall_q <= 1'b0;
        end else begin
            if (active_i && sck_fall_i)
                rx_q <= {din_i, rx_q[WORD_W-1:1]};
            if (load_i)
                seen_fall_q <= 1'b0;
            else if (active_i && sck_fall_i)
                seen_fall_q <= 1'b1;
            if (load_i)
                tx_q <= status_i;
            else if (active_i && sck_rise_i && seen_fall_q)
                tx_q <= {rx_q[WORD_W-1], tx_q[WORD_W-1:1]};
        end
    end

    assign rx_o   = rx_q;
    assign dout_o = tx_q[0];

    p_dout_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !sck_rise_i) |=> $stable(dout_o));
endmodule

// File: rtl/hbser_port.sv
module hbser_port
    import hbser_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_sel_n_i,
    input  logic              ser_din_i,
    output logic              ser_dout_o,
    output logic              ser_dout_en_o,
    input  logic [WORD_W-1:0] status_i,
    output logic [WORD_W-1:0] control_o,
    output logic              commit_o,
    output logic              status_clear_o
);
    localparam logic [WORD_W-1:0] CTRL_RST =
        {{CTRL_TOP_SET{1'b1}}, {(WORD_W-CTRL_TOP_SET){1'b0}}};

    logic [2:0] pins_sync;
    logic       sck_s, sel_s, din_s;
    logic       sck_q, sel_q;
    logic       sck_fall, sck_rise, sel_fall, sel_rise;
    logic       active, take;
    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] control_q;
    logic       clear_q;

    hbser_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ser_clk_i, ser_sel_n_i, ser_din_i}),
        .q_o   (pins_sync)
    );
    assign {sck_s, sel_s, din_s} = pins_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            sel_q <= 1'b1;
        end else begin
            sck_q <= sck_s;
            sel_q <= sel_s;
        end
    end

    assign sck_fall = sck_q & ~sck_s;
    assign sck_rise = ~sck_q & sck_s;
    assign sel_fall = sel_q & ~sel_s;
    assign sel_rise = ~sel_q & sel_s;

    hbser_frame_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_fall_i (sel_fall),
        .sel_rise_i (sel_rise),
        .sck_fall_i (sck_fall),
        .active_o   (active),
        .take_o     (take),
        .commit_o   (commit_o)
    );

    hbser_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sel_fall),
        .status_i   (status_i),
        .active_i   (active),
        .sck_fall_i (sck_fall),
        .sck_rise_i (sck_rise),
        .din_i      (din_s),
        .rx_o       (rx_word),
        .dout_o     (ser_dout_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            control_q <= CTRL_RST;
            clear_q   <= 1'b0;
        end else begin
            if (take) control_q <= rx_word;
            clear_q <= take & rx_word[CTRL_CLR_BIT];
        end
    end

    assign control_o      = control_q;
    assign status_clear_o = clear_q;
    assign ser_dout_en_o  = active;

    p_clear_with_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_clear_o |-> commit_o);
    p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_o |-> $stable(control_o));
    p_commit_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> !ser_dout_en_o);
    p_hiz_when_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_sel_n_i && $past(ser_sel_n_i) && $past(ser_sel_n_i, 2) && $past(ser_sel_n_i, 3))
        |-> !ser_dout_en_o);
endmodule

// File: tb/hbser_port_tb.sv
module hbser_port_tb;
    localparam int W = 16;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_sel_n = 1'b1, ser_din = 1'b0;
    logic ser_dout, ser_dout_en, commit, status_clear;
    logic [W-1:0] status, control;

    int checks = 0, errors = 0;
    int commit_cnt = 0, clear_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hbser_port u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ser_clk_i      (ser_clk),
        .ser_sel_n_i    (ser_sel_n),
        .ser_din_i      (ser_din),
        .ser_dout_o     (ser_dout),
        .ser_dout_en_o  (ser_dout_en),
        .status_i       (status),
        .control_o      (control),
        .commit_o       (commit),
        .status_clear_o (status_clear)
    );

    always @(negedge clk) begin
        if (commit) commit_cnt++;
        if (status_clear) clear_cnt++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input logic [W-1:0] din, input logic [W-1:0] extra,
                             input logic [W-1:0] stat, input int nclk);
        logic [2*W-1:0] seq;
        logic [W-1:0]   ctrl_before;
        int c0, k0;
        seq = {extra, din};
        ctrl_before = control;
        status = stat;
        @(negedge clk);
        ser_sel_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(ser_dout_en == 1'b0, "R2 enable not before third edge", ser_dout_en, 0);
        @(posedge clk); @(negedge clk);
        chk(ser_dout_en == 1'b1, "R2 enable on third edge", ser_dout_en, 1);
        chk(ser_dout == stat[0], "R3 prewarning bit at select fall", ser_dout, stat[0]);
        status = ~stat;
        cyc(2);
        for (int n = 0; n < nclk; n++) begin
            ser_din = seq[n];
            ser_clk = 1'b1;
            cyc(H);
            if (n < W)
                chk(ser_dout == stat[n], "R5 status bit at fall", ser_dout, stat[n]);
            else
                chk(ser_dout == seq[n-W], "R6 chained data at fall", ser_dout, seq[n-W]);
            ser_clk = 1'b0;
            cyc(H);
        end
        c0 = commit_cnt;
        k0 = clear_cnt;
        ser_sel_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(control == ctrl_before, "R7 control not before third edge", control, ctrl_before);
        @(posedge clk); @(negedge clk);
        chk(ser_dout_en == 1'b0, "R2 disabled after select rise", ser_dout_en, 0);
        if (nclk == W) begin
            chk(control == din, "R4 R7 committed word", control, din);
            chk(commit == 1'b1, "R7 commit on third edge", commit, 1);
        end else begin
            chk(control == ctrl_before, "R8 word discarded", control, ctrl_before);
        end
        cyc(4);
        chk(commit_cnt - c0 == ((nclk == W) ? 1 : 0), "R7 R8 commit pulse count",
            commit_cnt - c0, (nclk == W) ? 1 : 0);
        chk(clear_cnt - k0 == ((nclk == W && din[0]) ? 1 : 0), "R9 clear pulse count",
            clear_cnt - k0, (nclk == W && din[0]) ? 1 : 0);
        chk(ser_dout_en == 1'b0, "R2 idle output disabled", ser_dout_en, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        status = '0;
        cyc(5);
        rst_n = 1'b1;
        cyc(3);
        chk(control == 16'hE000, "R1 reset control", control, 16'hE000);
        chk(ser_dout_en == 1'b0, "R1 reset enable", ser_dout_en, 0);
        chk(commit == 1'b0 && status_clear == 1'b0, "R1 reset strobes", {commit, status_clear}, 0);
        for (int p = 0; p < 3; p++) begin
            for (int n = 0; n <= 20; n++) begin
                logic [W-1:0] din, extra, stat;
                din   = W'(32'h9E37 * (n + 1) + 32'h51ED * p);
                extra = W'(din * 3 + 1);
                stat  = W'((32'h7A35 * (n + 3)) ^ (32'h1357 * p));
                run_frame(din, extra, stat, n);
            end
        end
        run_frame(16'h0001, 16'h0000, 16'h8001, 16);
        run_frame(16'hFFFE, 16'hFFFF, 16'h7FFE, 16);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule